// File: doc/BRIEF.md
# Memory Access Fault Checker with Status Capture

This block sits beside the memory path and judges every CPU or DMA access against the page-map flags of the page being touched and the processor privilege level. An access is denied when the page is absent, or when user code strays into I/O space, into the low kernel region, or writes a page that is not writable. A denied access returns an all-ones fill value in the requested width during the cycle of the access. On the clock edge that ends that cycle, three 16-bit status registers are loaded. The general status word encodes the cause, the direction and the source. Bus status word 0 encodes the transfer kind and the upper address byte. Bus status word 1 holds the lower address half.

In the cycle after a denied access, the block pulses a bus-error line for a CPU fault or a level-7 interrupt line for a DMA fault. Each pulse is gated by the error-enable input. A strobe to the clear-status location sets all three status registers to 0xFFFF, which is also their reset value. Address translation and the memories themselves lie outside the block.

A two-state machine drives the fault response. It has two states, WATCH (no response pending) and SIGNAL (a response pulse is being driven), linked by three transitions. FAULT goes from WATCH to SIGNAL on a denied access. REPEAT keeps the machine in SIGNAL when another denied access arrives while it is signalling. RETURN goes from SIGNAL back to WATCH when no new fault arrives.

Top module: `acc_fault_guard`

## Requirements
- R1: When the address is below 0x400000 and `pg_flags[1:0]` is 00 (page absent), the access is denied as a page fault at both privilege levels.
- R2: With `acc_super` high, every access that is not a page fault is allowed, and an allowed access leaves the three status registers unchanged.
- R3: In user mode, an address at or above 0x400000 is denied as a user-I/O violation. This check outranks the checks of R4 and R5.
- R4: In user mode, an address whose bits 22:19 are all zero is denied as a kernel-space violation.
- R5: In user mode, a write to a page with `pg_flags[2]` (write enable) clear is denied with the kernel-violation code. Reads of that page, and writes to a page with `pg_flags[2]` set, are allowed.
- R6: For a CPU fault, the general status word is 0x8BFF (page fault), 0x9AFF (user-I/O) or 0x9BFF (kernel or write-protect). It is ORed with 0x4000 for a read and with 0x0400 when `par_irq_en` is high.
- R7: For a CPU fault, bus status 0 is 0x7C00 when `acc_size` is 01 (16-bit) or 1x (32-bit). For `acc_size` 00 (byte), it is 0x7D00 at an even address or 0x7E00 at an odd address. Address bits 23:16 are ORed into its low byte, and bus status 1 takes address bits 15:0.
- R8: For a DMA fault (`acc_dma` high), the status codes are 0xABFF, 0xBAFF and 0xBBFF, ORed with 0x4000 when the DMA reads and with 0x0400 when `par_irq_en` is high. Bus status 0 is 0x3C00 ORed with address bits 23:16.
- R9: In the cycle after a denied access sampled with `err_en` high, `bus_err` is high for one cycle for a CPU fault and `irq7` is high for one cycle for a DMA fault. When `err_en` is low, neither line rises.
- R10: During a denied read, `rd_fill` is all ones in the requested width: 0x000000FF for a byte, 0x0000FFFF for 16 bits, 0xFFFFFFFF for 32 bits. In all other cases `rd_fill` is zero.
- R11: Reset sets all three status registers to 0xFFFF, and so does `clr_stb`. When a denied access and `clr_stb` occur in the same cycle, the fault capture wins.
- R12: The status registers hold their values until they are cleared or overwritten by a later fault. Back-to-back faults give a response pulse in each following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 24 | Untranslated access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Transfer size: 00 = byte, 01 = 16-bit, 1x = 32-bit |
| acc_super | input | 1 | Processor in supervisor mode |
| pg_flags | input | 3 | Page-map flags: [2] write enable, [1:0] presence state (00 = absent) |
| acc_dma | input | 1 | Access issued by the DMA engine |
| err_en | input | 1 | Error enable; gates the bus-error and interrupt pulses |
| par_irq_en | input | 1 | Parity-interrupt enable; sets bit 10 of the status code |
| clr_stb | input | 1 | Write strobe to the clear-status location |
| acc_denied | output | 1 | The presented access is refused (same cycle) |
| rd_fill | output | 32 | All-ones fill value for a denied read |
| gen_status | output | 16 | General status register |
| bus_stat0 | output | 16 | Bus status register 0 |
| bus_stat1 | output | 16 | Bus status register 1 |
| bus_err | output | 1 | One-cycle bus-error pulse for a CPU fault |
| irq7 | output | 1 | One-cycle level-7 interrupt pulse for a DMA fault |

## Verification
The bench builds the block with its default 24-bit address and 32-bit data width. These widths expose every status field: the upper address byte lands in bus status 0, and all three fill widths can be observed. With these values, the directed scenarios reach each fault cause at both privilege levels and from both sources. They also reach the odd-byte and even-byte encodings, the clear-versus-fault collision, and back-to-back faults that hold the state machine in SIGNAL.

// File: rtl/acc_fault_pkg.sv
package acc_fault_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_PAGE   = 2'd1,
        CAUSE_USERIO = 2'd2,
        CAUSE_PRIV   = 2'd3
    } cause_t;

    typedef enum logic {
        ST_WATCH  = 1'b0,
        ST_SIGNAL = 1'b1
    } resp_state_t;

    typedef struct packed {
        logic [15:0] gen;
        logic [15:0] bs0;
        logic [15:0] bs1;
    } status_t;

    localparam logic [15:0] CLEARED_WORD = 16'hFFFF;
    localparam logic [1:0]  SZ_BYTE      = 2'b00;
    localparam logic [1:0]  SZ_WORD      = 2'b01;

endpackage

// File: rtl/acc_rule_eval.sv
module acc_rule_eval
    import acc_fault_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LOW_TOP  = 22,
    parameter int KERN_LO  = 19
) (
    input  logic [ADDR_W-1:KERN_LO] addr_hi,
    input  logic                    wr,
    input  logic                    sup,
    input  logic [2:0]              flags,
    output cause_t                  cause
);

    logic in_low;
    logic in_kern;

    // low space: all bits from LOW_TOP upward are zero
    assign in_low  = (addr_hi[ADDR_W-1:LOW_TOP] == '0);
    // kernel field: bits LOW_TOP down to KERN_LO all zero
    assign in_kern = (addr_hi[LOW_TOP:KERN_LO] == '0);

    always_comb begin
        if (in_low && (flags[1:0] == 2'b00)) begin
            cause = CAUSE_PAGE;
        end else if (sup) begin
            cause = CAUSE_NONE;
        end else if (!in_low) begin
            cause = CAUSE_USERIO;
        end else if (in_kern) begin
            cause = CAUSE_PRIV;
        end else if (wr && !flags[2]) begin
            cause = CAUSE_PRIV;
        end else begin
            cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/acc_word_build.sv
module acc_word_build
    import acc_fault_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  cause_t              cause,
    input  logic                valid,
    input  logic                dma,
    input  logic                wr,
    input  logic                pie,
    input  logic [1:0]          size,
    input  logic [ADDR_W-1:0]   addr,
    output status_t             words,
    output logic [DATA_W-1:0]   fill
);

    localparam int LANES = DATA_W / 8;

    logic [15:0] cause_bits;
    logic        deny_rd;

    always_comb begin
        unique case (cause)
            CAUSE_PAGE:   cause_bits = 16'h0BFF;
            CAUSE_USERIO: cause_bits = 16'h1AFF;
            CAUSE_PRIV:   cause_bits = 16'h1BFF;
            CAUSE_NONE:   cause_bits = CLEARED_WORD;
        endcase
    end

    always_comb begin
        words.gen = cause_bits
                  | (dma ? 16'hA000 : 16'h8000)
                  | (wr  ? 16'h0000 : 16'h4000)
                  | (pie ? 16'h0400 : 16'h0000);
        if (dma) begin
            words.bs0 = 16'h3C00;
        end else if (size == SZ_BYTE) begin
            words.bs0 = addr[0] ? 16'h7E00 : 16'h7D00;
        end else begin
            words.bs0 = 16'h7C00;
        end
        words.bs0 = words.bs0 | 16'(addr[ADDR_W-1:16]);
        words.bs1 = addr[15:0];
    end

    assign deny_rd = valid && (cause != CAUSE_NONE) && !wr;

    // one lane of fill per byte; lane 0 always, lane 1 for 16/32, rest for 32
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic lane_on;
        if (b == 0) begin : g_first
            assign lane_on = 1'b1;
        end else if (b == 1) begin : g_second
            assign lane_on = (size != SZ_BYTE);
        end else begin : g_upper
            assign lane_on = size[1];
        end
        assign fill[b*8 +: 8] = {8{deny_rd && lane_on}};
    end

endmodule

// File: rtl/acc_capture_fsm.sv
module acc_capture_fsm
    import acc_fault_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fire,
    input  logic    dma,
    input  logic    ee,
    input  logic    clr,
    input  status_t words,
    output status_t regs,
    output logic    bus_err,
    output logic    irq7
);

    resp_state_t state, nxt;
    logic        sig_dma;
    logic        sig_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WATCH;
        end else begin
            state <= nxt;
        end
    end

    // transitions: FAULT, REPEAT, RETURN
    always_comb begin
        unique case (state)
            ST_WATCH:  nxt = fire ? ST_SIGNAL : ST_WATCH;
            ST_SIGNAL: nxt = fire ? ST_SIGNAL : ST_WATCH;
        endcase
    end

    // capture of status words and response attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs    <= '{gen: CLEARED_WORD, bs0: CLEARED_WORD, bs1: CLEARED_WORD};
            sig_dma <= 1'b0;
            sig_en  <= 1'b0;
        end else if (fire) begin
            regs    <= words;
            sig_dma <= dma;
            sig_en  <= ee;
        end else if (clr) begin
            regs    <= '{gen: CLEARED_WORD, bs0: CLEARED_WORD, bs1: CLEARED_WORD};
        end
    end

    // outputs
    always_comb begin
        bus_err = 1'b0;
        irq7    = 1'b0;
        unique case (state)
            ST_WATCH: begin
                bus_err = 1'b0;
                irq7    = 1'b0;
            end
            ST_SIGNAL: begin
                bus_err = sig_en && !sig_dma;
                irq7    = sig_en && sig_dma;
            end
        endcase
    end

    assert_single_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_err, irq7}));

    assert_pulse_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err || irq7) |-> $past(fire && ee));

    assert_fault_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && clr) |=> (regs.bs1 == $past(words.bs1)));

endmodule

// File: rtl/acc_fault_guard.sv
module acc_fault_guard
    import acc_fault_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic              acc_super,
    input  logic [2:0]        pg_flags,
    input  logic              acc_dma,
    input  logic              err_en,
    input  logic              par_irq_en,
    input  logic              clr_stb,
    output logic              acc_denied,
    output logic [DATA_W-1:0] rd_fill,
    output logic [15:0]       gen_status,
    output logic [15:0]       bus_stat0,
    output logic [15:0]       bus_stat1,
    output logic              bus_err,
    output logic              irq7
);

    localparam int LOW_TOP = 22;
    localparam int KERN_LO = 19;

    cause_t  cause;
    status_t words;
    status_t regs;

    acc_rule_eval #(
        .ADDR_W  (ADDR_W),
        .LOW_TOP (LOW_TOP),
        .KERN_LO (KERN_LO)
    ) u_rules (
        .addr_hi (acc_addr[ADDR_W-1:KERN_LO]),
        .wr      (acc_write),
        .sup     (acc_super),
        .flags   (pg_flags),
        .cause   (cause)
    );

    assign acc_denied = acc_valid && (cause != CAUSE_NONE);

    acc_word_build #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_words (
        .cause (cause),
        .valid (acc_valid),
        .dma   (acc_dma),
        .wr    (acc_write),
        .pie   (par_irq_en),
        .size  (acc_size),
        .addr  (acc_addr),
        .words (words),
        .fill  (rd_fill)
    );

    acc_capture_fsm u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (acc_denied),
        .dma     (acc_dma),
        .ee      (err_en),
        .clr     (clr_stb),
        .words   (words),
        .regs    (regs),
        .bus_err (bus_err),
        .irq7    (irq7)
    );

    assign gen_status = regs.gen;
    assign bus_stat0  = regs.bs0;
    assign bus_stat1  = regs.bs1;

    assert_page_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_addr[ADDR_W-1:LOW_TOP] == '0) && (pg_flags[1:0] == 2'b00))
        |-> acc_denied);

    assert_super_allow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_super && (pg_flags[1:0] != 2'b00)) |-> !acc_denied);

    assert_bus_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_denied |=> (bus_stat1 == $past(acc_addr[15:0])));

    assert_fill_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_denied |-> (rd_fill == '0));

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !acc_denied) |=>
        ((gen_status == 16'hFFFF) && (bus_stat0 == 16'hFFFF) && (bus_stat1 == 16'hFFFF)));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_stb && !acc_denied) |=>
        ($stable(gen_status) && $stable(bus_stat0) && $stable(bus_stat1)));

endmodule

// File: tb/acc_fault_guard_tb.sv
module acc_fault_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic        acc_super = 1'b0;
    logic [2:0]  pg_flags = 3'b000;
    logic        acc_dma = 1'b0;
    logic        err_en = 1'b0;
    logic        par_irq_en = 1'b0;
    logic        clr_stb = 1'b0;
    logic        acc_denied;
    logic [31:0] rd_fill;
    logic [15:0] gen_status, bus_stat0, bus_stat1;
    logic        bus_err, irq7;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic        s_den;
    logic [31:0] s_fill;
    logic [15:0] s_gen, s_bs0, s_bs1;
    logic        s_be, s_irq, s_be2, s_irq2;

    always #2.5 clk = ~clk;

    acc_fault_guard u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_size(acc_size), .acc_super(acc_super),
        .pg_flags(pg_flags), .acc_dma(acc_dma), .err_en(err_en),
        .par_irq_en(par_irq_en), .clr_stb(clr_stb), .acc_denied(acc_denied),
        .rd_fill(rd_fill), .gen_status(gen_status), .bus_stat0(bus_stat0),
        .bus_stat1(bus_stat1), .bus_err(bus_err), .irq7(irq7)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access; samples comb outputs, registers after the edge, and pulse lines two edges later
    task automatic put(input logic [23:0] a, input logic wr, input logic [1:0] sz,
                       input logic sup, input logic [2:0] fl, input logic dma,
                       input logic ee, input logic pie, input logic vld, input logic clr);
        @(negedge clk);
        acc_addr = a; acc_write = wr; acc_size = sz; acc_super = sup;
        pg_flags = fl; acc_dma = dma; err_en = ee; par_irq_en = pie;
        acc_valid = vld; clr_stb = clr;
        #1;
        s_den = acc_denied; s_fill = rd_fill;
        @(posedge clk); #1;
        acc_valid = 1'b0; clr_stb = 1'b0;
        s_gen = gen_status; s_bs0 = bus_stat0; s_bs1 = bus_stat1;
        s_be = bus_err; s_irq = irq7;
        @(posedge clk); #1;
        s_be2 = bus_err; s_irq2 = irq7;
    endtask

    task automatic t_reset;
        check("R11 reset gen", gen_status, 16'hFFFF);
        check("R11 reset bs0", bus_stat0, 16'hFFFF);
        check("R11 reset bs1", bus_stat1, 16'hFFFF);
        check("R9 reset pulses", {bus_err, irq7}, 2'b00);
    endtask

    task automatic t_page_fault;
        put(24'h012344, 1'b0, 2'b01, 1'b0, 3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R1 user pf denied", s_den, 1'b1);
        check("R10 word fill", s_fill, 32'h0000FFFF);
        check("R6 pf read code", s_gen, 16'hCBFF);
        check("R7 bs0 word", s_bs0, 16'h7C01);
        check("R7 bs1", s_bs1, 16'h2344);
        check("R9 bus_err pulse", {s_be, s_irq}, 2'b10);
        check("R9 pulse one cycle", s_be2, 1'b0);
        put(24'h3F0A55, 1'b1, 2'b00, 1'b1, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R1 super pf denied", s_den, 1'b1);
        check("R10 write no fill", s_fill, 32'h0);
        check("R6 pf write pie code", s_gen, 16'h8FFF);
        check("R7 bs0 odd byte", s_bs0, 16'h7E3F);
        check("R7 bs1 odd", s_bs1, 16'h0A55);
    endtask

    task automatic t_super_ok;
        put(24'h600000, 1'b1, 2'b10, 1'b1, 3'b001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R2 super io allowed", s_den, 1'b0);
        check("R2 regs unchanged", s_gen, 16'h8FFF);
        check("R9 no pulse allowed", {s_be, s_irq}, 2'b00);
        put(24'h000100, 1'b0, 2'b00, 1'b1, 3'b010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R2 super kernel read", s_den, 1'b0);
        check("R10 allowed fill zero", s_fill, 32'h0);
    endtask

    task automatic t_user_io;
        put(24'h4A0010, 1'b1, 2'b10, 1'b0, 3'b111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R3 user io denied", s_den, 1'b1);
        check("R3 user io code", s_gen, 16'h9AFF);
        check("R7 bs0 long", s_bs0, 16'h7C4A);
        check("R7 bs1 io", s_bs1, 16'h0010);
        check("R9 ee low no pulse", {s_be, s_irq}, 2'b00);
        put(24'hC00004, 1'b0, 2'b10, 1'b0, 3'b111, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R3 user io read code", s_gen, 16'hDAFF);
        check("R10 long fill", s_fill, 32'hFFFFFFFF);
        check("R7 bs0 high", s_bs0, 16'h7CC0);
        check("R9 bus_err io", s_be, 1'b1);
    endtask

    task automatic t_kernel;
        put(24'h070002, 1'b0, 2'b00, 1'b0, 3'b011, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R4 kernel denied", s_den, 1'b1);
        check("R4 kernel code", s_gen, 16'hDBFF);
        check("R7 bs0 even byte", s_bs0, 16'h7D07);
        check("R10 byte fill", s_fill, 32'h000000FF);
    endtask

    task automatic t_write_protect;
        put(24'h1C0000, 1'b1, 2'b01, 1'b0, 3'b010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R5 wp denied", s_den, 1'b1);
        check("R5 wp code", s_gen, 16'h9BFF);
        check("R7 bs0 wp", s_bs0, 16'h7C1C);
        put(24'h000000, 1'b0, 2'b00, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R11 clear gen", s_gen, 16'hFFFF);
        check("R11 clear bs0", s_bs0, 16'hFFFF);
        check("R11 clear bs1", s_bs1, 16'hFFFF);
        put(24'h1C0000, 1'b0, 2'b01, 1'b0, 3'b010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R5 wp read allowed", s_den, 1'b0);
        check("R12 regs hold", s_gen, 16'hFFFF);
        put(24'h1C0000, 1'b1, 2'b01, 1'b0, 3'b110, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R5 writable allowed", s_den, 1'b0);
    endtask

    task automatic t_dma;
        put(24'h123456, 1'b0, 2'b01, 1'b0, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R8 dma pf code", s_gen, 16'hEFFF);
        check("R8 dma bs0", s_bs0, 16'h3C12);
        check("R8 dma bs1", s_bs1, 16'h3456);
        check("R9 irq7 pulse", {s_be, s_irq}, 2'b01);
        check("R9 irq7 one cycle", s_irq2, 1'b0);
        put(24'h500000, 1'b1, 2'b00, 1'b0, 3'b111, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 dma io code", s_gen, 16'hBAFF);
        check("R8 dma bs0 io", s_bs0, 16'h3C50);
        check("R9 dma ee low", s_irq, 1'b0);
        put(24'h000080, 1'b0, 2'b10, 1'b0, 3'b001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R8 dma kernel code", s_gen, 16'hFBFF);
        check("R9 dma kernel irq", s_irq, 1'b1);
    endtask

    task automatic t_clear_collide;
        put(24'h0000AA, 1'b0, 2'b00, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R11 fault wins gen", s_gen, 16'hCBFF);
        check("R11 fault wins bs0", s_bs0, 16'h7D00);
        check("R11 fault wins bs1", s_bs1, 16'h00AA);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        acc_addr = 24'h400000; acc_write = 1'b1; acc_size = 2'b01; acc_super = 1'b0;
        pg_flags = 3'b111; acc_dma = 1'b0; err_en = 1'b1; par_irq_en = 1'b0;
        acc_valid = 1'b1;
        @(posedge clk); #1;
        check("R12 first fault code", gen_status, 16'h9AFF);
        check("R12 first pulse", bus_err, 1'b1);
        acc_addr = 24'h012000; acc_write = 1'b0; pg_flags = 3'b000;
        @(posedge clk); #1;
        acc_valid = 1'b0;
        check("R12 second pulse", bus_err, 1'b1);
        check("R12 second code", gen_status, 16'hCBFF);
        check("R12 second bs1", bus_stat1, 16'h2000);
        @(posedge clk); #1;
        check("R12 pulse ends", bus_err, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_page_fault();
        t_super_ok();
        t_user_io();
        t_kernel();
        t_write_protect();
        t_dma();
        t_clear_collide();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

endmodule